// File: doc/BRIEF.md
# Locked-update PWM channel

This block is one pulse-width modulated output channel, programmed through four word registers on a small synchronous write/read port: a free-running counter, a period, a duty count and a control word. Period and duty count in clock cycles with no prescaler. The output is left aligned, so the duty phase comes first in every period. Two control bits give the duty-phase level and the idle-phase level independently.

Software never writes the running settings directly. Period, duty and the two level bits are written into a staging copy. The staging copy moves into the running copy as a whole at the next period boundary, and only while the lock bit in the control word is clear. Setting the lock lets software rewrite any number of fields over many cycles. One control write that clears the lock and carries the new levels then releases everything together. No period ever shows a mix of old and new values.

Top module: `pwm_lockstep_chan`

## Requirements
- R1: After reset, all four registers read zero and the output is low.
- R2: The register slot is chosen by addr[3:2]: 0 = counter, 1 = period, 2 = duty, 3 = control. addr[1:0] are ignored. Period, duty and control read back the last written (staged) values. A write to the counter slot changes nothing.
- R3: While running, the counter steps 0, 1, … up to period−1 and then returns to 0. With a period of 0 or 1 it stays at 0.
- R4: While running, the output equals control bit 3 when the counter is below the committed duty, and control bit 4 otherwise. Both level bits take the values they had at the last commit.
- R5: A committed duty that is nonzero and at least the period gives a constant bit-3 level. A duty of zero gives a constant bit-4 level.
- R6: The channel runs only while control bit 0 is 1 and bits 2:1 equal 01. At any other time the counter holds at 0 and the output drives the committed idle level.
- R7: A period boundary is a clock edge at which the counter wraps to 0, or any clock edge while the channel is not running. With the lock clear, the staged values are committed at a boundary and never between two boundaries.
- R8: While control bit 6 (lock) is set, nothing is committed, and the running waveform keeps its period, duty and levels.
- R9: A control write that clears the lock commits period, duty and both level bits together at the next boundary. A write that lands on the boundary edge itself is included in that commit.
- R10: Every complete running period has exactly the length and duty-phase count of a single committed setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registers and the counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the slot chosen by addr |
| addr | input | AW | Byte address; bits 3:2 choose the slot |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the slot chosen by addr, valid in the same cycle |
| pwm_out | output | 1 | PWM output |

## Verification
A behavioural model is compared with the output and the read port on every cycle. The model is driven with these patterns:
- Plain running with both level choices, which separates the duty comparison from the level selection.
- Duty values of zero and of at least the period, which expose off-by-one errors at the comparison edges.
- Unlocked mid-period writes, which show whether a commit waits for the wrap.
- Locked sequences whose unlock write is swept across every cycle offset of a period, so one case lands on the boundary edge itself.

A separate period monitor measures each finished period from the output pin. This catches any period whose length or duty-phase count belongs to no single setting.

// File: rtl/pwm_lockstep_chan.sv
module pwm_lockstep_chan #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pwm_out
);
  localparam int EN_B   = 0;
  localparam int HI_B   = 3;
  localparam int LO_B   = 4;
  localparam int LOCK_B = 6;
  localparam logic [1:0] MODE_CONT = 2'b01;
  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_PER  = 2'd1;
  localparam logic [1:0] SEL_DUTY = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  logic [DW-1:0] ctrl_q, per_sh, duty_sh, per_act, duty_act, cnt;
  logic          hi_act, lo_act;
  logic [DW-1:0] ctrl_n, per_n, duty_n;
  logic [DW:0]   cnt_inc;
  logic [1:0]    slot;
  logic          run, run_n, last, bound, commit;
  logic          unused_addr;

  assign slot        = addr[3:2];
  assign unused_addr = ^addr;

  assign ctrl_n = (wr_en && slot == SEL_CTRL) ? wdata : ctrl_q;
  assign per_n  = (wr_en && slot == SEL_PER)  ? wdata : per_sh;
  assign duty_n = (wr_en && slot == SEL_DUTY) ? wdata : duty_sh;

  assign run   = ctrl_q[EN_B] && (ctrl_q[2:1] == MODE_CONT);
  assign run_n = ctrl_n[EN_B] && (ctrl_n[2:1] == MODE_CONT);

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign last    = cnt_inc >= {1'b0, per_act};
  assign bound   = !run || last;
  assign commit  = bound && !ctrl_n[LOCK_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      per_sh   <= '0;
      duty_sh  <= '0;
      per_act  <= '0;
      duty_act <= '0;
      hi_act   <= 1'b0;
      lo_act   <= 1'b0;
      cnt      <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      per_sh  <= per_n;
      duty_sh <= duty_n;
      if (commit) begin
        per_act  <= per_n;
        duty_act <= duty_n;
        hi_act   <= ctrl_n[HI_B];
        lo_act   <= ctrl_n[LO_B];
      end
      cnt <= (run_n && run && !last) ? cnt_inc[DW-1:0] : '0;
    end
  end

  assign pwm_out = (run && (cnt < duty_act)) ? hi_act : lo_act;

  always_comb begin
    unique case (slot)
      SEL_CNT:  rdata = cnt;
      SEL_PER:  rdata = per_sh;
      SEL_DUTY: rdata = duty_sh;
      default:  rdata = ctrl_q;
    endcase
  end
endmodule

module pwm_lockstep_chan_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] per_act,
  input logic [DW-1:0] duty_act,
  input logic          hi_act,
  input logic          lo_act,
  input logic          pwm_out
);
  logic running;
  assign running = ctrl_q[0] && (ctrl_q[2:1] == 2'b01);

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && per_act > 1) |-> (cnt < per_act));

  assert_idle_cnt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cnt == '0));

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_out == lo_act));

  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && duty_act != '0 && duty_act >= per_act) |-> (pwm_out == hi_act));

  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> (pwm_out == lo_act));

  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[6] |-> ($stable(per_act) && $stable(duty_act) && $stable(hi_act) && $stable(lo_act)));

  assert_no_midperiod_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt != '0) |-> ($stable(per_act) && $stable(duty_act) && $stable(hi_act) && $stable(lo_act)));
endmodule

bind pwm_lockstep_chan pwm_lockstep_chan_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .cnt(cnt), .per_act(per_act),
  .duty_act(duty_act), .hi_act(hi_act), .lo_act(lo_act), .pwm_out(pwm_out)
);

// File: tb/pwm_lockstep_chan_tb.sv
module pwm_lockstep_chan_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CNT = 4'h0, A_PER = 4'h4, A_DUTY = 4'h8, A_CTRL = 4'hC;
  localparam logic [DW-1:0] C_NORM = 32'h0B, C_INV = 32'h13, LOCK = 32'h40;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic pwm_out;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";
  bit cmp_en = 1'b0, mon_en = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  pwm_lockstep_chan #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  // behavioural reference
  logic [DW-1:0] m_ctrl, m_per, m_duty;
  longint unsigned a_per, a_duty, m_cnt;
  bit a_hi, a_lo;

  function automatic bit runs(logic [DW-1:0] c);
    return c[0] && c[2:1] == 2'b01;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_per <= '0; m_duty <= '0;
      a_per <= 0; a_duty <= 0; a_hi <= 0; a_lo <= 0; m_cnt <= 0;
    end else begin
      logic [DW-1:0] nc, np, nd;
      bit wrap, edge_ok;
      nc = m_ctrl; np = m_per; nd = m_duty;
      if (wr_en) begin
        if (addr[3:2] == 2'd1) np = wdata;
        if (addr[3:2] == 2'd2) nd = wdata;
        if (addr[3:2] == 2'd3) nc = wdata;
      end
      wrap = (m_cnt + 1 >= a_per);
      edge_ok = !runs(m_ctrl) || wrap;
      if (edge_ok && !nc[6]) begin
        a_per <= np; a_duty <= nd; a_hi <= nc[3]; a_lo <= nc[4];
      end
      if (runs(nc) && runs(m_ctrl) && !wrap) m_cnt <= m_cnt + 1;
      else m_cnt <= 0;
      m_ctrl <= nc; m_per <= np; m_duty <= nd;
    end
  end

  function automatic logic [DW-1:0] exp_rd();
    case (addr[3:2])
      2'd0: return m_cnt[DW-1:0];
      2'd1: return m_per;
      2'd2: return m_duty;
      default: return m_ctrl;
    endcase
  endfunction

  task automatic chk(string t, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", t, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk({tag, " pwm_out"}, pwm_out, (runs(m_ctrl) && m_cnt < a_duty) ? a_hi : a_lo);
      chk({tag, " rdata"}, rdata, exp_rd());
    end
  end

  // period integrity monitor (R10)
  longint unsigned s_per, s_duty, p_len, p_hi;
  bit s_lvl, p_valid = 1'b0;
  always @(negedge clk) begin
    if (!mon_en || !runs(m_ctrl)) p_valid = 1'b0;
    else begin
      if (m_cnt == 0) begin
        if (p_valid) begin
          longint unsigned L;
          L = (s_per < 1) ? 1 : s_per;
          chk("R10 period length", p_len, L);
          chk("R10 duty-phase count", p_hi, (s_duty < L) ? s_duty : L);
        end
        s_per = a_per; s_duty = a_duty; s_lvl = a_hi;
        p_len = 0; p_hi = 0; p_valid = 1'b1;
      end
      p_len++;
      if (pwm_out == s_lvl) p_hi++;
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0; addr = A_CTRL;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdchk(logic [AW-1:0] a, logic [DW-1:0] e, string t);
    @(negedge clk); #1; addr = a;
    @(negedge clk);
    chk(t, rdata, e);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    idle(3); #1 rst_n = 1'b1;
    // R1 reset state
    rdchk(A_CNT, 0, "R1 counter");
    rdchk(A_PER, 0, "R1 period");
    rdchk(A_DUTY, 0, "R1 duty");
    rdchk(A_CTRL, 0, "R1 control");
    chk("R1 pwm_out", pwm_out, 0);
    cmp_en = 1'b1;

    // R2 register access, low address bits ignored
    tag = "R2";
    wr(A_PER, 10); wr(A_DUTY | 4'h1, 3);
    rdchk(A_PER | 4'h3, 10, "R2 period readback");
    rdchk(A_DUTY | 4'h2, 3, "R2 duty readback");

    // R3 R4 normal running
    tag = "R4";
    wr(A_CTRL, C_NORM); idle(35);
    tag = "R3";
    wr(A_CNT, 32'h5); idle(12);

    // R7 unlocked mid-period update waits for the wrap
    tag = "R7";
    idle(2); wr(A_PER, 7); idle(3); wr(A_DUTY, 5); idle(30);

    // R4 inverted levels
    tag = "R4";
    wr(A_CTRL, C_INV); idle(25);

    // R5 duty beyond period and zero duty
    tag = "R5";
    wr(A_DUTY, 9); idle(20);
    wr(A_DUTY, 7); idle(16);
    wr(A_DUTY, 0); idle(16);

    // R3 degenerate periods
    tag = "R3";
    wr(A_DUTY, 1); wr(A_PER, 1); idle(8);
    wr(A_PER, 0); idle(8);

    // R6 idle modes
    tag = "R6";
    wr(A_PER, 6); wr(A_DUTY, 2); wr(A_CTRL, C_NORM); idle(10);
    wr(A_CTRL, 32'h0D); idle(10);
    wr(A_CTRL, 32'h1A); idle(10);

    // R8 R9 R10 locked updates, unlock swept across offsets
    wr(A_CTRL, C_NORM); idle(10);
    mon_en = 1'b1;
    for (int d = 0; d < 10; d++) begin
      logic [DW-1:0] oldc, newc;
      oldc = (d % 2 == 0) ? C_NORM : C_INV;
      newc = (d % 2 == 0) ? C_INV : C_NORM;
      tag = "R8";
      wr(A_CTRL, oldc | LOCK); idle(d);
      wr(A_PER, 5 + (d % 4)); idle(4);
      wr(A_DUTY, 1 + (d % 3)); idle(12 + d);
      tag = "R9";
      wr(A_CTRL, newc); idle(20);
    end
    mon_en = 1'b0;
    tag = "R8";
    wr(A_CTRL, C_NORM | LOCK); wr(A_PER, 12); idle(30);
    rdchk(A_PER, 12, "R8 staged period readback");
    tag = "R9";
    wr(A_CTRL, C_NORM); idle(30);

    done = 1'b1;
    summary();
  end
endmodule